// File: doc/BRIEF.md
# Clock Supervisor with Backup Switchover

The block takes a main clock and a reference clock that is always running, and produces the system clock. It counts main-clock edges in fixed windows of reference-clock cycles and sorts each window into one of three classes: no edges (missing), more edges than the programmable limit `lim_max` (too fast), or in range. A main clock that runs too fast is blocked, so the output carries no clock. A missing main clock hands the output over to the reference clock, which acts as the backup. After two in-range windows in a row, the output goes back to the main clock without any software action.

Each handover to the backup sets a sticky detection flag. Software reads the flag and an interrupt enable through a small register port clocked by the reference clock. The interrupt request is the flag gated by the enable. A halt input freezes the register and disables supervision, and both clock paths to the output are gated off. When halt is released, the block continues with the state it held. A reset returns the register to zero. A static enable input `cfg_en` turns supervision off, and the main clock then reaches the output unchanged.

Top module: `clk_guard`

## Requirements
- R1: With `cfg_en` low, `sys_clk` follows `main_clk` exactly, at any frequency and also when it stops, and the detection flag is never set.
- R2: When a window holds more than `lim_max` main edges, the main clock is blocked and the over-frequency clock never reaches `sys_clk`. Without the backup, the output is quiet.
- R3: From the blocked state, two in-range windows in a row bring the main clock back onto `sys_clk`.
- R4: A window with zero main edges switches `sys_clk` to the reference clock.
- R5: From the backup, two in-range windows in a row return `sys_clk` to the main clock. An over-frequency main clock keeps the backup in place.
- R6: Every entry into the backup sets the flag, which is read back at `reg_rdata` bit 0. The flag stays set until a write with bit 0 set clears it. `reg_rdata` bit 1 holds the interrupt enable, which is loaded from `reg_wdata` bit 1 on every write.
- R7: `irq` is high only while both the flag and the interrupt enable are set.
- R8: While `halt` is high, writes are ignored, the flag and the enable keep their values, and `sys_clk` carries no clock from either source.
- R9: After `halt` falls, the block resumes with its held state and register. A reset clears the register to zero.
- R10: A change of source never produces a high pulse on `sys_clk` shorter than the shorter half-period of the two clocks, and the two sources are never enabled at the same time.
- R11: After reset, `reg_rdata` and `irq` are zero and the main clock is the selected source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 1 | Always-running reference clock, which also serves as the backup |
| main_clk | input | 1 | Main clock under supervision |
| cfg_en | input | 1 | Static supervision enable |
| halt | input | 1 | Halt mode: freezes the register and disables supervision |
| lim_max | input | CNT_W | Largest allowed number of main edges per window |
| reg_we | input | 1 | Register write strobe (ref_clk domain) |
| reg_wdata | input | 2 | Bit 0: write one to clear the flag; bit 1: interrupt enable |
| reg_rdata | output | 2 | Bit 0: detection flag; bit 1: interrupt enable |
| irq | output | 1 | Interrupt request |
| sys_clk | output | 1 | System clock output |

## Verification
A change of source is decided at a window boundary. A fault therefore takes effect within two windows of 16 reference cycles each, and a recovery within three windows. Each path also carries two synchronizer stages, which add a few cycles more. For this reason the bench holds each main-clock condition for 80 reference cycles. It then counts `sys_clk` rising edges over 40 reference cycles and sorts the count into quiet, backup, main or raw-fast bands. Register effects appear one reference edge after a write, so the bench drives writes at a falling edge and reads at the next falling edge. Halt gating is checked only after several cycles, once both gates have had time to close.

// File: rtl/clk_guard.sv
`timescale 1ns/1ps
module clk_guard #(
  parameter int CNT_W = 8,
  parameter int WIN   = 16
) (
  input  logic             rst_n,
  input  logic             ref_clk,
  input  logic             main_clk,
  input  logic             cfg_en,
  input  logic             halt,
  input  logic [CNT_W-1:0] lim_max,
  input  logic             reg_we,
  input  logic [1:0]       reg_wdata,
  output logic [1:0]       reg_rdata,
  output logic             irq,
  output logic             sys_clk
);
  localparam int WIN_W = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN - 1);

  typedef enum logic [1:0] {S_MAIN = 2'd0, S_FILT = 2'd1, S_BACK = 2'd2} src_t;

  function automatic logic [CNT_W-1:0] g2b(input logic [CNT_W-1:0] g);
    logic [CNT_W-1:0] b;
    b[CNT_W-1] = g[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // main-domain edge counter, gray coded for the crossing
  logic [CNT_W-1:0] mbin, mgray, mnext;
  assign mnext = mbin + 1'b1;

  always_ff @(posedge main_clk or negedge rst_n)
    if (!rst_n) begin
      mbin  <= '0;
      mgray <= '0;
    end else begin
      mbin  <= mnext;
      mgray <= mnext ^ (mnext >> 1);
    end

  logic [CNT_W-1:0] gs1, gs2, gbin, gprev, gdiff;
  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      gs1 <= '0;
      gs2 <= '0;
    end else begin
      gs1 <= mgray;
      gs2 <= gs1;
    end

  assign gbin  = g2b(gs2);
  assign gdiff = gbin - gprev;

  logic [WIN_W-1:0] win_cnt;
  logic win_end, is_miss, is_fast, is_good, active;
  src_t st;
  logic good_seen, flag, ie, set_flag;

  assign win_end  = (win_cnt == WIN_LAST);
  assign is_miss  = (gdiff == '0);
  assign is_fast  = (gdiff > lim_max);
  assign is_good  = !is_miss && !is_fast;
  assign active   = cfg_en && !halt;
  assign set_flag = active && win_end && is_miss && (st != S_BACK);

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      win_cnt   <= '0;
      gprev     <= '0;
      st        <= S_MAIN;
      good_seen <= 1'b0;
    end else if (!active) begin
      win_cnt <= '0;
      gprev   <= gbin;
      if (!cfg_en) begin
        st        <= S_MAIN;
        good_seen <= 1'b0;
      end
    end else begin
      win_cnt <= win_end ? '0 : win_cnt + 1'b1;
      if (win_end) begin
        gprev <= gbin;
        case (st)
          S_MAIN: begin
            good_seen <= 1'b0;
            if (is_miss)      st <= S_BACK;
            else if (is_fast) st <= S_FILT;
          end
          S_FILT: begin
            if (is_miss) begin
              st        <= S_BACK;
              good_seen <= 1'b0;
            end else if (is_fast) begin
              good_seen <= 1'b0;
            end else if (good_seen) begin
              st        <= S_MAIN;
              good_seen <= 1'b0;
            end else begin
              good_seen <= 1'b1;
            end
          end
          default: begin
            if (!is_good) begin
              good_seen <= 1'b0;
            end else if (good_seen) begin
              st        <= S_MAIN;
              good_seen <= 1'b0;
            end else begin
              good_seen <= 1'b1;
            end
          end
        endcase
      end
    end

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      flag <= 1'b0;
      ie   <= 1'b0;
    end else if (!halt) begin
      if (reg_we) begin
        ie <= reg_wdata[1];
        if (reg_wdata[0]) flag <= 1'b0;
      end
      if (set_flag) flag <= 1'b1;
    end

  assign reg_rdata = {ie, flag};
  assign irq       = flag & ie;

  // glitch-free source gating
  logic req_m_r, req_b_r;
  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      req_m_r <= 1'b0;
      req_b_r <= 1'b0;
    end else begin
      req_m_r <= active && (st == S_MAIN);
      req_b_r <= active && (st == S_BACK);
    end

  logic m_s1, m_on, b_s1, b_on, m_clr;
  assign m_clr = !rst_n || (st == S_BACK);

  always_ff @(negedge main_clk or posedge m_clr)
    if (m_clr) begin
      m_s1 <= 1'b0;
      m_on <= 1'b0;
    end else begin
      m_s1 <= req_m_r && !b_on;
      m_on <= m_s1;
    end

  always_ff @(negedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      b_s1 <= 1'b0;
      b_on <= 1'b0;
    end else begin
      b_s1 <= req_b_r && !m_on;
      b_on <= b_s1;
    end

  assign sys_clk = cfg_en ? ((main_clk & m_on) | (ref_clk & b_on)) : main_clk;
endmodule

// File: rtl/clk_guard_chk.sv
`timescale 1ns/1ps
module clk_guard_chk (
  input logic       ref_clk,
  input logic       rst_n,
  input logic       cfg_en,
  input logic       halt,
  input logic [1:0] st,
  input logic       flag,
  input logic       ie,
  input logic       m_on,
  input logic       b_on
);
  a_r1_no_flag_when_off: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !cfg_en |-> !$rose(flag));

  a_r2_fast_blocked: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (st == 2'd1 && $past(st) == 2'd1 && $past(st, 2) == 2'd1 && $past(st, 3) == 2'd1) |-> !m_on);

  a_r6_flag_on_backup: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(flag) |-> st == 2'd2);

  a_r8_halt_freeze: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (halt && $past(halt)) |-> ($stable(flag) && $stable(ie)));

  a_r8_halt_no_backup: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (halt && $past(halt) && $past(halt, 2) && $past(halt, 3)) |-> !b_on);

  a_r10_one_source: assert property (@(posedge ref_clk) disable iff (!rst_n)
    cfg_en |-> $onehot0({m_on, b_on}));
endmodule

bind clk_guard clk_guard_chk u_chk (
  .ref_clk(ref_clk), .rst_n(rst_n), .cfg_en(cfg_en), .halt(halt),
  .st(st), .flag(flag), .ie(ie), .m_on(m_on), .b_on(b_on)
);

// File: tb/clk_guard_test.sv
`timescale 1ns/1ps
module clk_guard_test;
  logic       rst_n = 1'b0;
  logic       ref_clk = 1'b0;
  logic       main_clk = 1'b0;
  logic       cfg_en = 1'b1;
  logic       halt = 1'b0;
  logic [7:0] lim_max = 8'd48;
  logic       reg_we = 1'b0;
  logic [1:0] reg_wdata = 2'b00;
  logic [1:0] reg_rdata;
  logic       irq, sys_clk;
  int         mmode = 0;   // 0 normal 4 ns, 1 fast 1 ns, 2 stopped
  int         nchk = 0, nfail = 0;

  clk_guard uut (.*);

  always #4 ref_clk = ~ref_clk;

  always begin
    if (mmode == 2) begin
      main_clk = 1'b0;
      @(mmode);
    end else if (mmode == 1) #0.5 main_clk = ~main_clk;
    else #2 main_clk = ~main_clk;
  end

  int  ecnt = 0;
  bit  counting = 0, watch = 0;
  real t_rise = 0.0, min_hi = 1000.0;
  always @(posedge sys_clk) begin
    if (counting) ecnt++;
    t_rise = $realtime;
  end
  always @(negedge sys_clk)
    if (watch && ($realtime - t_rise) < min_hi) min_hi = $realtime - t_rise;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // 0 quiet, 1 backup, 2 main, 3 raw fast, 7 other
  task automatic measure(output int code);
    ecnt = 0;
    counting = 1;
    repeat (40) @(negedge ref_clk);
    counting = 0;
    if (ecnt == 0) code = 0;
    else if (ecnt >= 30 && ecnt <= 50) code = 1;
    else if (ecnt >= 65 && ecnt <= 95) code = 2;
    else if (ecnt > 200) code = 3;
    else code = 7;
  endtask

  task automatic wr(input logic [1:0] d);
    @(negedge ref_clk);
    reg_we = 1'b1;
    reg_wdata = d;
    @(negedge ref_clk);
    reg_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge ref_clk);
    rst_n = 1'b0;
    repeat (3) @(negedge ref_clk);
    rst_n = 1'b1;
    @(negedge ref_clk);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  // {mode[1:0], expected source code[1:0], expected flag}
  localparam logic [4:0] VEC [0:8] = '{
    {2'd0, 2'd2, 1'b0}, {2'd1, 2'd0, 1'b0}, {2'd0, 2'd2, 1'b0},
    {2'd2, 2'd1, 1'b1}, {2'd0, 2'd2, 1'b1}, {2'd1, 2'd0, 1'b1},
    {2'd2, 2'd1, 1'b1}, {2'd1, 2'd1, 1'b1}, {2'd0, 2'd2, 1'b1}
  };

  initial begin
    repeat (150000) @(posedge ref_clk);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

  initial begin
    int code;
    int prev;
    string tag;
    repeat (3) @(negedge ref_clk);
    rst_n = 1'b1;
    @(negedge ref_clk);
    chk(reg_rdata == 2'b00, "R11 rdata", reg_rdata, 0);
    chk(irq == 1'b0, "R11 irq", irq, 0);

    prev = 0;
    for (int i = 0; i < 9; i++) begin
      mmode = int'(VEC[i][4:3]);
      watch = (i == 3 || i == 4);
      repeat (80) @(negedge ref_clk);
      measure(code);
      watch = 0;
      if (i == 0) tag = "R11 source";
      else if (mmode == 2) tag = "R4 source";
      else if (mmode == 1) tag = "R2 source";
      else if (prev == 1) tag = "R3 source";
      else tag = "R5 source";
      chk(code == int'(VEC[i][2:1]), tag, code, int'(VEC[i][2:1]));
      chk(reg_rdata[0] == VEC[i][0], "R6 flag", reg_rdata[0], VEC[i][0]);
      chk(irq == 1'b0, "R7 irq without enable", irq, 0);
      if (i == 4) chk(min_hi > 1.9, "R10 shortest high pulse ps", int'(min_hi * 1000.0), 2000);
      prev = mmode;
    end

    wr(2'b10);
    chk(reg_rdata == 2'b11, "R6 enable write keeps flag", reg_rdata, 3);
    chk(irq == 1'b1, "R7 irq enabled", irq, 1);
    wr(2'b11);
    chk(reg_rdata == 2'b10, "R6 write one clears", reg_rdata, 2);
    chk(irq == 1'b0, "R7 irq after clear", irq, 0);

    mmode = 2;
    repeat (80) @(negedge ref_clk);
    chk(reg_rdata == 2'b11, "R6 flag set again", reg_rdata, 3);
    chk(irq == 1'b1, "R7 irq raised", irq, 1);

    halt = 1'b1;
    repeat (5) @(negedge ref_clk);
    wr(2'b01);
    chk(reg_rdata == 2'b11, "R8 write ignored in halt", reg_rdata, 3);
    measure(code);
    chk(code == 0, "R8 no clock in halt", code, 0);
    halt = 1'b0;
    repeat (10) @(negedge ref_clk);
    measure(code);
    chk(code == 1, "R9 backup resumes", code, 1);
    chk(reg_rdata == 2'b11, "R9 register kept", reg_rdata, 3);

    do_reset();
    chk(reg_rdata == 2'b00, "R9 reset clears register", reg_rdata, 0);

    cfg_en = 1'b0;
    mmode = 1;
    do_reset();
    repeat (80) @(negedge ref_clk);
    measure(code);
    chk(code == 3, "R1 fast passes when off", code, 3);
    chk(reg_rdata[0] == 1'b0, "R1 no flag when off", reg_rdata[0], 0);
    mmode = 2;
    repeat (80) @(negedge ref_clk);
    measure(code);
    chk(code == 0, "R1 stopped passes when off", code, 0);
    chk(reg_rdata[0] == 1'b0, "R1 no flag on stop when off", reg_rdata[0], 0);

    finish_up();
  end
endmodule